// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block holds the interrupt sources of an I2C master/slave controller whose transmit and receive FIFOs are 64 entries deep. It takes in several kinds of input: single-cycle event pulses from the bus engine, the FIFO fill levels and their programmed thresholds, the enable bit, the busy flag of the master/slave state machines, the CPU strobes for the data register, and one read strobe for each clear register. From these it keeps twelve raw status bits.

A software-writable mask selects which raw bits reach the combined interrupt line. The masked vector is the raw vector ANDed with the mask. The interrupt output is a registered OR of the masked bits. A transmit abort also raises a hold signal, which keeps the transmit FIFO flushed. While the hold is high, CPU writes are not forwarded as FIFO pushes. The hold stays up until software reads the abort-clear register.

Every raw bit is written at the clock edge that follows its condition. A bit's set condition and its clear condition can arrive in the same cycle. In that case the set wins.

Top module: `i2c_irq_unit`

## Requirements
- R1: The mask comes out of reset as 0x8FF. A mask write loads data bits 11:0, and `maskRead` returns the mask with bits 31:12 always zero. The bit order of the raw, masked and mask vectors is fixed:
  - bit 0: rx_under
  - bit 1: rx_over
  - bit 2: rx_full
  - bit 3: tx_over
  - bit 4: tx_empty
  - bit 5: rd_req
  - bit 6: tx_abrt
  - bit 7: rx_done
  - bit 8: activity
  - bit 9: stop_det
  - bit 10: start_det
  - bit 11: gen_call
- R2: `maskedStatus` equals `rawStatus` AND the mask. `irq` is the OR of `maskedStatus` from the previous cycle.
- R3: While enabled, raw bit 4 is 1 exactly when `txLevel <= txThresh`. While disabled, it follows `busy`.
- R4: Raw bit 2 is 1 exactly when the block is enabled and `rxLevel >= rxThresh`.
- R5: The overflow and underflow bits set as follows:
  - bit 3 sets on `dataWr` while `txLevel` is 64;
  - bit 1 sets on `evRxByte` while `rxLevel` is 64;
  - bit 0 sets on `dataRd` while `rxLevel` is 0.
- R6: While disabled, bits 3, 1 and 0 keep their value as long as `busy` is 1. They clear once the block is disabled and `busy` is 0.
- R7: Bit 8 sets whenever `busy` is 1 while enabled. It is sticky and clears only on disable, `clrRd[8]`, `clrAll`, or reset.
- R8: Raw bit 6 sets on `evTxAbrt`, and `txFlushHold` follows bit 6. While the hold is up, `txPush` stays 0 whatever `dataWr` does. `clrRd[6]` (or `clrAll`) removes the hold.
- R9: Bits 5, 7, 9, 10 and 11 set on their event pulses and clear on `clrRd` at their own index. Bit 11 also clears on disable.
- R10: `clrAll` clears every bit except the level bits 4 and 2. If a set condition and any clear condition arrive in the same cycle, the set wins.
- R11: `txPush` is `dataWr` with the transmit FIFO below 64 entries and no flush hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable bit |
| busy | input | 1 | Master/slave state machines not idle |
| evStart | input | 1 | START or repeated START seen |
| evStop | input | 1 | STOP seen |
| evGenCall | input | 1 | General call address acknowledged |
| evRdReq | input | 1 | Remote master requests data from this slave |
| evRxDone | input | 1 | Slave transmit byte not acknowledged |
| evTxAbrt | input | 1 | Transmit abort |
| evRxByte | input | 1 | Byte arrived from the bus |
| txLevel | input | 7 | Transmit FIFO fill level |
| txThresh | input | 7 | Transmit threshold |
| rxLevel | input | 7 | Receive FIFO fill level |
| rxThresh | input | 7 | Receive threshold |
| dataWr | input | 1 | CPU write of the data/command register |
| dataRd | input | 1 | CPU read of the data register |
| clrRd | input | 12 | Per-bit clear-register read strobes (bits 4 and 2 unused) |
| clrAll | input | 1 | Read of the global interrupt-clear register |
| maskWr | input | 1 | Mask register write strobe |
| maskWrData | input | 32 | Mask write data |
| maskRead | output | 32 | Mask register read value |
| rawStatus | output | 12 | Raw status bits |
| maskedStatus | output | 12 | Raw status AND mask |
| irq | output | 1 | Registered combined interrupt |
| txFlushHold | output | 1 | Keep transmit FIFO flushed |
| txPush | output | 1 | Forward CPU write to transmit FIFO |

## Verification
The hardest state to reach from the ports is a disabled controller that still holds overflow or underflow flags while its state machines remain busy. To get there, the bench first drives the FIFO levels to exactly 64 or 0 while enabled and fires the CPU and byte strobes. It then drops `enable` with `busy` held high and checks that the flags persist. Finally it drops `busy` and checks that they clear. Same-cycle set/clear collisions and the abort hold's blocking of writes are driven directly by directed pulses.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_SRC = 12;

  // Bit positions of the status vector (software-visible order).
  localparam int B_RX_UNDER = 0;
  localparam int B_RX_OVER  = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_OVER  = 3;
  localparam int B_TX_EMPTY = 4;
  localparam int B_RD_REQ   = 5;
  localparam int B_TX_ABRT  = 6;
  localparam int B_RX_DONE  = 7;
  localparam int B_ACTIVITY = 8;
  localparam int B_STOP     = 9;
  localparam int B_START    = 10;
  localparam int B_GEN_CALL = 11;

  localparam logic [NUM_SRC-1:0] MASK_RESET = 12'h8FF;
  // Bits that track a level instead of latching an event.
  localparam logic [NUM_SRC-1:0] LEVEL_BITS = 12'h014;
  // Bits that hold through disable until the state machines go idle.
  localparam logic [NUM_SRC-1:0] IDLE_CLR_BITS = 12'h00B;
  // Sticky bits that disabling clears outright.
  localparam logic [NUM_SRC-1:0] DIS_CLR_BITS = 12'h900;

  typedef struct packed {
    logic [NUM_SRC-1:0] setV;
    logic [NUM_SRC-1:0] clrV;
  } irqStrobes_t;
endpackage

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               enable,
  input  logic               busy,
  input  logic               evStart,
  input  logic               evStop,
  input  logic               evGenCall,
  input  logic               evRdReq,
  input  logic               evRxDone,
  input  logic               evTxAbrt,
  input  logic               evRxByte,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   txThresh,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxThresh,
  input  logic               dataWr,
  input  logic               dataRd,
  input  logic [NUM_SRC-1:0] clrRd,
  input  logic               clrAll,
  input  logic               holdIn,
  output irqStrobes_t        strb,
  output logic               txPush
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic txFull, rxFull, rxEmpty;
  logic lvlTxEmpty, lvlRxFull;
  logic idleOff, disabled;
  logic [NUM_SRC-1:0] swClr;

  assign txFull   = (txLevel == FULL_LVL);
  assign rxFull   = (rxLevel == FULL_LVL);
  assign rxEmpty  = (rxLevel == '0);
  assign disabled = !enable;
  assign idleOff  = disabled && !busy;

  assign lvlTxEmpty = enable ? (txLevel <= txThresh) : busy;
  assign lvlRxFull  = enable && (rxLevel >= rxThresh);

  // Software clear paths: own strobe or global clear, never on level bits.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_swclr
    if (LEVEL_BITS[i]) begin : g_lvl
      assign swClr[i] = 1'b0;
    end else begin : g_evt
      assign swClr[i] = clrRd[i] || clrAll;
    end
  end

  always_comb begin
    strb.setV = '0;
    strb.setV[B_RX_UNDER] = dataRd && rxEmpty;
    strb.setV[B_RX_OVER]  = evRxByte && rxFull;
    strb.setV[B_RX_FULL]  = lvlRxFull;
    strb.setV[B_TX_OVER]  = dataWr && txFull;
    strb.setV[B_TX_EMPTY] = lvlTxEmpty;
    strb.setV[B_RD_REQ]   = evRdReq;
    strb.setV[B_TX_ABRT]  = evTxAbrt;
    strb.setV[B_RX_DONE]  = evRxDone;
    strb.setV[B_ACTIVITY] = enable && busy;
    strb.setV[B_STOP]     = evStop;
    strb.setV[B_START]    = evStart;
    strb.setV[B_GEN_CALL] = evGenCall;

    strb.clrV = swClr
              | (IDLE_CLR_BITS & {NUM_SRC{idleOff}})
              | (DIS_CLR_BITS & {NUM_SRC{disabled}});
    // Level bits: clear whenever the level is absent.
    strb.clrV[B_RX_FULL]  = !lvlRxFull;
    strb.clrV[B_TX_EMPTY] = !lvlTxEmpty;
  end

  assign txPush = dataWr && !txFull && !holdIn;
endmodule

// File: rtl/i2c_irq_dp.sv
module i2c_irq_dp
  import i2c_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strb,
  input  logic               maskWr,
  input  logic [REG_W-1:0]   maskWrData,
  output logic [REG_W-1:0]   maskRead,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic               irq
);
  logic [NUM_SRC-1:0] rawQ, maskQ;
  logic irqQ;

  // Set has priority over every clear path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= strb.setV | (rawQ & ~strb.clrV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       maskQ <= MASK_RESET;
    else if (maskWr) maskQ <= maskWrData[NUM_SRC-1:0];
  end

  assign maskedStatus = rawQ & maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |maskedStatus;
  end

  assign rawStatus = rawQ;
  assign irq       = irqQ;
  assign maskRead  = {{(REG_W-NUM_SRC){1'b0}}, maskQ};
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int REG_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               busy,
  input  logic               evStart,
  input  logic               evStop,
  input  logic               evGenCall,
  input  logic               evRdReq,
  input  logic               evRxDone,
  input  logic               evTxAbrt,
  input  logic               evRxByte,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   txThresh,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxThresh,
  input  logic               dataWr,
  input  logic               dataRd,
  input  logic [NUM_SRC-1:0] clrRd,
  input  logic               clrAll,
  input  logic               maskWr,
  input  logic [REG_W-1:0]   maskWrData,
  output logic [REG_W-1:0]   maskRead,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic               irq,
  output logic               txFlushHold,
  output logic               txPush
);
  irqStrobes_t strb;

  i2c_irq_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .enable(enable), .busy(busy),
    .evStart(evStart), .evStop(evStop), .evGenCall(evGenCall),
    .evRdReq(evRdReq), .evRxDone(evRxDone), .evTxAbrt(evTxAbrt),
    .evRxByte(evRxByte),
    .txLevel(txLevel), .txThresh(txThresh),
    .rxLevel(rxLevel), .rxThresh(rxThresh),
    .dataWr(dataWr), .dataRd(dataRd),
    .clrRd(clrRd), .clrAll(clrAll),
    .holdIn(txFlushHold),
    .strb(strb), .txPush(txPush)
  );

  i2c_irq_dp #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .maskWr(maskWr), .maskWrData(maskWrData), .maskRead(maskRead),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irq(irq)
  );

  assign txFlushHold = rawStatus[B_TX_ABRT];
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               busy,
  input logic               evStart,
  input logic               evRxByte,
  input logic               dataWr,
  input logic               dataRd,
  input logic [NUM_SRC-1:0] clrRd,
  input logic               clrAll,
  input logic [NUM_SRC-1:0] rawStatus,
  input logic [NUM_SRC-1:0] maskedStatus,
  input logic               irq,
  input logic               txFlushHold,
  input logic               txPush
);
  a_r8_push_blocked: assert property (@(posedge clk) disable iff (!rstN)
    txFlushHold |-> !txPush);

  a_r2_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == (|$past(maskedStatus))));

  a_r4_rxfull_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rawStatus[B_RX_FULL]);

  a_r3_txempty_busy: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (rawStatus[B_TX_EMPTY] == $past(busy)));

  a_r7_activity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus[B_ACTIVITY] && enable && !clrRd[B_ACTIVITY] && !clrAll)
      |=> rawStatus[B_ACTIVITY]);

  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !busy && !dataWr && !dataRd && !evRxByte)
      |=> (rawStatus[B_TX_OVER] == 1'b0 && rawStatus[B_RX_OVER] == 1'b0
           && rawStatus[B_RX_UNDER] == 1'b0));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    evStart |=> rawStatus[B_START]);
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/i2c_irq_unit_test.sv
module i2c_irq_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable, busy, evStart, evStop, evGenCall, evRdReq, evRxDone, evTxAbrt, evRxByte;
  logic [6:0] txLevel, txThresh, rxLevel, rxThresh;
  logic dataWr, dataRd, clrAll, maskWr;
  logic [11:0] clrRd;
  logic [31:0] maskWrData, maskRead;
  logic [11:0] rawStatus, maskedStatus;
  logic irq, txFlushHold, txPush;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_irq_unit uut (.*);

  // Row: en, busy, txLevel, txThresh, rxLevel, rxThresh, expTxEmpty, expRxFull
  localparam logic [31:0] LVL_TAB [8] = '{
    {1'b1, 1'b0, 7'd5,  7'd5,  7'd3,  7'd4,  1'b1, 1'b0},
    {1'b1, 1'b0, 7'd6,  7'd5,  7'd4,  7'd4,  1'b0, 1'b1},
    {1'b1, 1'b0, 7'd0,  7'd0,  7'd64, 7'd64, 1'b1, 1'b1},
    {1'b1, 1'b0, 7'd64, 7'd63, 7'd0,  7'd1,  1'b0, 1'b0},
    {1'b0, 1'b1, 7'd64, 7'd0,  7'd64, 7'd0,  1'b1, 1'b0},
    {1'b0, 1'b0, 7'd0,  7'd10, 7'd10, 7'd0,  1'b0, 1'b0},
    {1'b1, 1'b1, 7'd1,  7'd2,  7'd63, 7'd64, 1'b1, 1'b0},
    {1'b1, 1'b0, 7'd0,  7'd0,  7'd0,  7'd0,  1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    enable = 1; busy = 0;
    {evStart, evStop, evGenCall, evRdReq, evRxDone, evTxAbrt, evRxByte} = '0;
    txLevel = 10; txThresh = 0; rxLevel = 5; rxThresh = 10;
    dataWr = 0; dataRd = 0; clrAll = 0; clrRd = '0; maskWr = 0; maskWrData = '0;
  endtask

  // Inputs already driven; wait one edge, sample on the next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 mask reset", maskRead, 32'h0000_08FF);
    chk("R11 raw reset", {20'h0, rawStatus}, 32'h0);
    chk("R2 irq reset", {31'h0, irq}, 32'h0);
    chk("R8 hold reset", {31'h0, txFlushHold}, 32'h0);

    // Level table for R3 and R4
    for (int i = 0; i < 8; i++) begin
      {enable, busy, txLevel, txThresh, rxLevel, rxThresh} = LVL_TAB[i][31:2];
      step();
      chk("R3 tx_empty level", {31'h0, rawStatus[4]}, {31'h0, LVL_TAB[i][1]});
      chk("R4 rx_full level", {31'h0, rawStatus[2]}, {31'h0, LVL_TAB[i][0]});
    end
    idle();
    clrAll = 1; step(); clrAll = 0; step();
    chk("R10 clear all after table", {20'h0, rawStatus}, 32'h0);

    // R1 mask write, reserved bits zero
    maskWr = 1; maskWrData = 32'hFFFF_F123; step(); maskWr = 0;
    chk("R1 mask write", maskRead, 32'h0000_0123);

    // R5 overflow / underflow set
    txLevel = 64; dataWr = 1;
    #1 chk("R11 push blocked when full", {31'h0, txPush}, 32'h0);
    step(); dataWr = 0; txLevel = 10;
    chk("R5 tx_over", {31'h0, rawStatus[3]}, 32'h1);
    rxThresh = 100; rxLevel = 64; evRxByte = 1; step(); evRxByte = 0;
    chk("R5 rx_over", {31'h0, rawStatus[1]}, 32'h1);
    rxLevel = 0; dataRd = 1; step(); dataRd = 0; rxLevel = 5;
    chk("R5 rx_under", {31'h0, rawStatus[0]}, 32'h1);

    // R6 hold while disabled and busy, clear when idle
    enable = 0; busy = 1; step(); step();
    chk("R6 hold disabled busy", {29'h0, rawStatus[3], rawStatus[1], rawStatus[0]}, 32'h7);
    busy = 0; step();
    chk("R6 clear disabled idle", {29'h0, rawStatus[3], rawStatus[1], rawStatus[0]}, 32'h0);
    idle(); step();

    // R2 mask and irq timing
    maskWr = 1; maskWrData = 32'h1; step(); maskWr = 0;
    evStop = 1; step(); evStop = 0;
    chk("R2 masked stop hidden", {20'h0, maskedStatus}, 32'h0);
    step();
    chk("R2 irq stays low", {31'h0, irq}, 32'h0);
    rxLevel = 0; dataRd = 1; step(); dataRd = 0; rxLevel = 5;
    chk("R2 masked rx_under", {20'h0, maskedStatus}, 32'h1);
    chk("R2 irq lags one cycle", {31'h0, irq}, 32'h0);
    step();
    chk("R2 irq raised", {31'h0, irq}, 32'h1);
    clrRd[0] = 1; step(); clrRd = '0;
    chk("R2 rx_under cleared", {31'h0, rawStatus[0]}, 32'h0);
    step();
    chk("R2 irq dropped", {31'h0, irq}, 32'h0);
    clrRd[9] = 1; step(); clrRd = '0;
    chk("R9 stop cleared", {31'h0, rawStatus[9]}, 32'h0);

    // R7 activity
    busy = 1; step(); busy = 0; step();
    chk("R7 activity sticky", {31'h0, rawStatus[8]}, 32'h1);
    clrRd[8] = 1; step(); clrRd = '0;
    chk("R7 activity own clear", {31'h0, rawStatus[8]}, 32'h0);
    busy = 1; step(); busy = 0; clrAll = 1; step(); clrAll = 0;
    chk("R7 activity clear all", {31'h0, rawStatus[8]}, 32'h0);
    busy = 1; step(); busy = 0; enable = 0; step(); enable = 1;
    chk("R7 activity disable", {31'h0, rawStatus[8]}, 32'h0);

    // R8 abort hold
    evTxAbrt = 1; step(); evTxAbrt = 0;
    chk("R8 hold set", {31'h0, txFlushHold}, 32'h1);
    dataWr = 1;
    #1 chk("R8 write blocked", {31'h0, txPush}, 32'h0);
    step(); dataWr = 0;
    chk("R8 hold persists", {31'h0, txFlushHold}, 32'h1);
    clrRd[6] = 1; step(); clrRd = '0;
    chk("R8 hold released", {31'h0, txFlushHold}, 32'h0);
    dataWr = 1;
    #1 chk("R11 write forwarded", {31'h0, txPush}, 32'h1);
    step(); dataWr = 0;

    // R9 event bits
    evGenCall = 1; evRdReq = 1; step(); {evGenCall, evRdReq} = '0;
    chk("R9 gen_call rd_req set", {30'h0, rawStatus[11], rawStatus[5]}, 32'h3);
    enable = 0; step(); enable = 1;
    chk("R9 gen_call disable clear", {30'h0, rawStatus[11], rawStatus[5]}, 32'h1);
    clrRd[5] = 1; step(); clrRd = '0;
    chk("R9 rd_req clear", {31'h0, rawStatus[5]}, 32'h0);

    // R10 clear all spares level bits; set beats clear
    txThresh = 20; evStart = 1; evStop = 1; evRxDone = 1; step();
    {evStart, evStop, evRxDone} = '0;
    chk("R9 start stop rx_done set", {29'h0, rawStatus[10:9], rawStatus[7]}, 32'h7);
    clrAll = 1; step(); clrAll = 0;
    chk("R10 clear all events", {20'h0, rawStatus}, 32'h010);
    evStart = 1; clrRd[10] = 1; clrAll = 1; step();
    evStart = 0; clrRd = '0; clrAll = 0;
    chk("R10 set wins", {31'h0, rawStatus[10]}, 32'h1);

    finish_run();
  end
endmodule